// File: doc/BRIEF.md
# Programmable Resolution Time Tag Counter

This block is a free-running real-time tag counter for a serial avionics bus controller. The counter advances on ticks from one of two sources. The first is an internal microsecond timebase, divided down to a tick period of 2, 4, 8, 16, 32 or 64 microseconds. The second is an external tag clock pin, which is synchronised and edge-detected inside the block. A host can read the count at any time. A host write loads a new count and restarts the internal division chain.

Message logic raises a start strobe or an end strobe when a message begins or ends. On each strobe the block emits a one-cycle valid pulse together with a snapshot of the count, and a storage engine writes that snapshot to memory. When the count wraps from all ones to zero on a tick, the block raises a one-cycle rollover pulse, which an interrupt controller can use as a request source.

Top module: `time_tag_counter`

## Requirements
- R1: While reset is high and in the first cycle after it, `tag_count` is zero, `cap_valid` is 2'b00 and `tag_rollover` is low.
- R2: For `res_sel` values 0 to 5, the count increments once every (2 << `res_sel`) microseconds. One microsecond is CLKS_PER_US clocks. The first increment after a host write lands exactly (2 << `res_sel`) × CLKS_PER_US clock edges after the edge that loaded the write.
- R3: For `res_sel` values 6 and 7, the count increments once per rising edge of `ext_tag_clk`, on the third clock edge after the rise. Internal ticks have no effect in these modes. In modes 0 to 5, edges on `ext_tag_clk` have no effect.
- R4: A host write (`host_wr` high) loads `host_wdata` into the count on the next edge. This takes precedence over an increment due in the same cycle. The write also restarts the internal timebase and the prescaler.
- R5: `tag_count` always shows the current counter value.
- R6: A high `som_strobe` gives `cap_valid[0]` high for exactly one cycle after the next edge. `cap_value[15:0]` then holds the count as it stood in the strobe cycle, before any increment at that edge.
- R7: A high `eom_strobe` does the same on `cap_valid[1]` and `cap_value[31:16]`. Both strobes may be high in the same cycle, and then both channels fire.
- R8: When a tick takes the count from 16'hFFFF to zero, `tag_rollover` is high for exactly the one cycle in which the count first reads zero. A host write never raises `tag_rollover`.
- R9: Without a host write, the count changes between consecutive cycles only by an increment of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| res_sel | input | 3 | Resolution select: 0 to 5 give 2 to 64 us, 6 and 7 select the external clock |
| ext_tag_clk | input | 1 | External tag clock, asynchronous |
| host_wr | input | 1 | Host write enable |
| host_wdata | input | 16 | Value loaded on a host write |
| tag_count | output | 16 | Current count, for host reads |
| som_strobe | input | 1 | Start-of-message capture strobe |
| eom_strobe | input | 1 | End-of-message capture strobe |
| cap_valid | output | 2 | Capture valid: bit 0 for start, bit 1 for end |
| cap_value | output | 32 | Captured counts: [15:0] for start, [31:16] for end |
| tag_rollover | output | 1 | One-cycle pulse on wrap to zero |

## Verification
Every internal resolution is run from a fresh host write, and the count is sampled one edge before and exactly at each expected increment. This separates the six tick periods and exposes any off-by-one in the divider or the prescaler. External pulses are applied in external mode, to count edges and their three-edge latency. They are also applied in an internal mode, where they must leave the count unchanged. Strobes are placed in the very cycle of an increment, so that a snapshot taken before the increment can be told apart from one taken after it. A write is also placed in the cycle of an increment, and loads near 16'hFFFF separate a tick wrap, which must pulse, from a loaded wrap, which must not.

// File: rtl/tt_pkg.sv
package tt_pkg;

    localparam int TT_WIDTH      = 16;
    localparam int TT_MAX_PERIOD = 64;
    localparam int TT_PRE_W      = $clog2(TT_MAX_PERIOD);
    localparam int TT_CHANNELS   = 2;

    typedef enum logic [2:0] {
        RES_2US   = 3'd0,
        RES_4US   = 3'd1,
        RES_8US   = 3'd2,
        RES_16US  = 3'd3,
        RES_32US  = 3'd4,
        RES_64US  = 3'd5,
        RES_EXT_A = 3'd6,
        RES_EXT_B = 3'd7
    } res_sel_e;

    typedef struct packed {
        logic                valid;
        logic [TT_WIDTH-1:0] value;
    } cap_t;

    function automatic logic is_external(input logic [2:0] sel);
        return (sel == RES_EXT_A) || (sel == RES_EXT_B);
    endfunction

    function automatic logic [TT_PRE_W:0] period_us(input logic [2:0] sel);
        if (is_external(sel))
            return (TT_PRE_W+1)'(TT_MAX_PERIOD);
        return (TT_PRE_W+1)'(2) << sel;
    endfunction

endpackage

// File: rtl/tt_us_timebase.sv
module tt_us_timebase #(
    parameter int CLKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic us_tick
);
    localparam int DIV_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLKS_PER_US - 1);

    logic [DIV_W-1:0] div_cnt;

    assign us_tick = (div_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || us_tick)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end

    generate
        if (CLKS_PER_US > 1) begin : g_spaced
            AST_US_SPACED: assert property (@(posedge clk) disable iff (rst)
                us_tick |=> !us_tick); // R2
        end
    endgenerate

endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       us_tick,
    input  logic [2:0] sel,
    output logic       tick
);
    import tt_pkg::*;

    logic [TT_PRE_W-1:0] pre_cnt;
    logic [TT_PRE_W:0]   period;
    logic                reached;

    assign period  = period_us(sel);
    assign reached = ({1'b0, pre_cnt} >= (period - 1'b1));
    assign tick    = us_tick && reached;

    always_ff @(posedge clk) begin
        if (rst || clr || tick)
            pre_cnt <= '0;
        else if (us_tick)
            pre_cnt <= pre_cnt + 1'b1;
    end

endmodule

// File: rtl/tt_ext_edge.sv
module tt_ext_edge (
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    output logic edge_pulse
);
    logic [2:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= '0;
        else
            sync_q <= {sync_q[1:0], ext_in};
    end

    assign edge_pulse = sync_q[1] && !sync_q[2];

    AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |=> !edge_pulse); // R3

endmodule

// File: rtl/time_tag_counter.sv
module time_tag_counter #(
    parameter int TAG_W       = tt_pkg::TT_WIDTH,
    parameter int CLKS_PER_US = 100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         res_sel,
    input  logic               ext_tag_clk,
    input  logic               host_wr,
    input  logic [TAG_W-1:0]   host_wdata,
    output logic [TAG_W-1:0]   tag_count,
    input  logic               som_strobe,
    input  logic               eom_strobe,
    output logic [1:0]         cap_valid,
    output logic [2*TAG_W-1:0] cap_value,
    output logic               tag_rollover
);
    import tt_pkg::*;

    localparam int NCH = TT_CHANNELS;

    logic             us_tick;
    logic             int_tick;
    logic             ext_tick;
    logic             advance;
    logic [TAG_W-1:0] count_q;
    logic [NCH-1:0]   strobes;

    tt_us_timebase #(.CLKS_PER_US(CLKS_PER_US)) u_timebase (
        .clk     (clk),
        .rst     (rst),
        .clr     (host_wr),
        .us_tick (us_tick)
    );

    tt_prescaler u_prescaler (
        .clk     (clk),
        .rst     (rst),
        .clr     (host_wr),
        .us_tick (us_tick),
        .sel     (res_sel),
        .tick    (int_tick)
    );

    tt_ext_edge u_ext (
        .clk        (clk),
        .rst        (rst),
        .ext_in     (ext_tag_clk),
        .edge_pulse (ext_tick)
    );

    assign advance = is_external(res_sel) ? ext_tick : int_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q      <= '0;
            tag_rollover <= 1'b0;
        end else if (host_wr) begin
            count_q      <= host_wdata;
            tag_rollover <= 1'b0;
        end else begin
            tag_rollover <= advance && (count_q == '1);
            if (advance)
                count_q <= count_q + 1'b1;
        end
    end

    assign tag_count = count_q;
    assign strobes   = {eom_strobe, som_strobe};

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_cap
            logic             valid_q;
            logic [TAG_W-1:0] value_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    valid_q <= 1'b0;
                    value_q <= '0;
                end else begin
                    valid_q <= strobes[ch];
                    if (strobes[ch])
                        value_q <= count_q;
                end
            end

            assign cap_valid[ch]                 = valid_q;
            assign cap_value[ch*TAG_W +: TAG_W]  = value_q;
        end
    endgenerate

    AST_ROLL_WRAP: assert property (@(posedge clk) disable iff (rst)
        tag_rollover |-> (tag_count == '0) && ($past(tag_count) == '1)); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> (tag_count == $past(host_wdata)) && !tag_rollover); // R4

    AST_STEP_ONLY: assert property (@(posedge clk) disable iff (rst)
        !host_wr |=> (tag_count == $past(tag_count)) ||
                     (tag_count == $past(tag_count) + 1'b1)); // R9

    AST_SOM_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        som_strobe |=> cap_valid[0] && (cap_value[TAG_W-1:0] == $past(tag_count))); // R6

    AST_EOM_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        eom_strobe |=> cap_valid[1] && (cap_value[2*TAG_W-1:TAG_W] == $past(tag_count))); // R7

endmodule

// File: tb/tb_time_tag_counter.sv
module tb_time_tag_counter;

    localparam int C = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  res_sel;
    logic        ext_tag_clk;
    logic        host_wr;
    logic [15:0] host_wdata;
    logic [15:0] tag_count;
    logic        som_strobe;
    logic        eom_strobe;
    logic [1:0]  cap_valid;
    logic [31:0] cap_value;
    logic        tag_rollover;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    time_tag_counter #(.TAG_W(16), .CLKS_PER_US(C)) dut (
        .clk          (clk),
        .rst          (rst),
        .res_sel      (res_sel),
        .ext_tag_clk  (ext_tag_clk),
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .tag_count    (tag_count),
        .som_strobe   (som_strobe),
        .eom_strobe   (eom_strobe),
        .cap_valid    (cap_valid),
        .cap_value    (cap_value),
        .tag_rollover (tag_rollover)
    );

    localparam logic [2:0] SEL_VEC [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
    localparam logic [15:0] BASE_VEC [6] =
        '{16'h0010, 16'h1234, 16'h7FFE, 16'hA000, 16'h00FF, 16'hC3C3};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] val);
        host_wr    = 1'b1;
        host_wdata = val;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_pulse();
        ext_tag_clk = 1'b1;
        wait_edges(3);
        ext_tag_clk = 1'b0;
        wait_edges(3);
    endtask

    initial begin
        rst = 1'b1; res_sel = 3'd0; ext_tag_clk = 1'b0; host_wr = 1'b0;
        host_wdata = '0; som_strobe = 1'b0; eom_strobe = 1'b0;
        wait_edges(3);
        check("R1 count in reset", tag_count, 0);
        check("R1 valid in reset", cap_valid, 0);
        check("R1 rollover in reset", tag_rollover, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 count after reset", tag_count, 0);
        check("R1 rollover after reset", tag_rollover, 0);

        // R2 and R5: vector table over the internal resolutions
        for (int i = 0; i < 6; i++) begin
            int per;
            per = (2 << SEL_VEC[i]) * C;
            res_sel = SEL_VEC[i];
            do_write(BASE_VEC[i]);
            check("R4 load", tag_count, BASE_VEC[i]);
            wait_edges(per - 1);
            check("R2 before first tick", tag_count, BASE_VEC[i]);
            wait_edges(1);
            check("R2 first tick", tag_count, BASE_VEC[i] + 16'd1);
            wait_edges(per - 1);
            check("R5 read between ticks", tag_count, BASE_VEC[i] + 16'd1);
            wait_edges(1);
            check("R2 second tick", tag_count, BASE_VEC[i] + 16'd2);
        end

        // R3: external clock mode, latency and internal ticks ignored
        res_sel = 3'd6;
        do_write(16'h0200);
        ext_tag_clk = 1'b1;
        wait_edges(2);
        check("R3 ext not yet", tag_count, 16'h0200);
        wait_edges(1);
        check("R3 ext third edge", tag_count, 16'h0201);
        wait_edges(2);
        ext_tag_clk = 1'b0;
        wait_edges(3);
        for (int p = 0; p < 3; p++) ext_pulse();
        res_sel = 3'd7;
        ext_pulse();
        wait_edges(100);
        check("R3 ext edge count", tag_count, 16'h0205);

        // R3: external edges ignored in internal mode
        res_sel = 3'd5;
        do_write(16'h0300);
        for (int p = 0; p < 5; p++) ext_pulse();
        check("R3 ext ignored internal", tag_count, 16'h0300);

        // R4: write in the cycle of a due increment
        res_sel = 3'd0;
        do_write(16'h0400);
        wait_edges(2 * C - 1);
        do_write(16'h0500);
        check("R4 write beats tick", tag_count, 16'h0500);
        wait_edges(2 * C - 1);
        check("R4 prescaler restarted", tag_count, 16'h0500);
        wait_edges(1);
        check("R4 tick after restart", tag_count, 16'h0501);

        // R6, R7: captures in the cycle of an increment
        do_write(16'h0100);
        wait_edges(2 * C - 1);
        som_strobe = 1'b1;
        @(negedge clk);
        som_strobe = 1'b0;
        check("R6 som valid", cap_valid, 2'b01);
        check("R6 som value pre-increment", cap_value[15:0], 16'h0100);
        check("R6 count advanced", tag_count, 16'h0101);
        eom_strobe = 1'b1;
        @(negedge clk);
        eom_strobe = 1'b0;
        check("R6 som one cycle / R7 eom valid", cap_valid, 2'b10);
        check("R7 eom value", cap_value[31:16], 16'h0101);
        som_strobe = 1'b1; eom_strobe = 1'b1;
        @(negedge clk);
        som_strobe = 1'b0; eom_strobe = 1'b0;
        check("R7 both strobes", cap_valid, 2'b11);
        check("R7 both values", cap_value, 32'h0101_0101);
        @(negedge clk);
        check("R7 valids drop", cap_valid, 2'b00);

        // R8, R9: rollover by tick, none by write
        do_write(16'hFFFE);
        wait_edges(2 * C);
        check("R9 step to FFFF", tag_count, 16'hFFFF);
        wait_edges(2 * C - 1);
        check("R8 no pulse before wrap", tag_rollover, 0);
        wait_edges(1);
        check("R8 wrap count", tag_count, 16'h0000);
        check("R8 wrap pulse", tag_rollover, 1);
        wait_edges(1);
        check("R8 pulse one cycle", tag_rollover, 0);
        do_write(16'hFFFF);
        do_write(16'h0000);
        check("R8 write wrap no pulse", tag_rollover, 0);
        check("R8 write wrap count", tag_count, 16'h0000);

        // R1: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run reset", tag_count, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule